// File: doc/BRIEF.md
# Registered Binary-Tree Arbiter

This block merges N independent valid/ready request streams into one output stream. It is a tree of two-input merge nodes. Each node has a single-word holding register and a flag that marks the register as empty. A node takes a word only while its register is empty. It offers the held word to the next stage and clears the register only when that stage accepts the word. A ready that arrives while the node is empty is ignored, so no word is lost.

Every node is fair to its two sides. When both sides offer a word together, the node grants the side it did not grant last time. When N is not a power of two, an unpaired stream at any level goes straight up to the next level, with no register added. The tree depth seen by an input is the number of nodes on its path to the root. That depth sets the latency through an idle tree.

Top module: `arb_tree`

## Requirements
- R1: While reset is applied and on the first cycle after it, `out_valid` is low, because every node's register starts empty.
- R2: `in_ready[i]` is high only in a cycle where `in_valid[i]` is high, its leaf node is empty and that node grants input i.
- R3: While `out_valid` is high and `out_ready` is low, on the next cycle `out_valid` stays high and `out_data` is unchanged.
- R4: After an output handshake (`out_valid` and `out_ready` both high at a clock edge), `out_valid` is low for the following cycle, because a node never reloads in the cycle it empties.
- R5: `out_ready` held high while `out_valid` is low has no effect. A word offered later is still delivered intact.
- R6: Input 0 offers one word while the other inputs are idle. `out_ready` is low on the first cycle and high afterwards. With N=5, the word appears on `out_data` with `out_valid` high in the third cycle after it was first offered.
- R7: Every word accepted at an input leaves the output exactly once. Words from the same input leave in the order they were accepted.
- R8: A node whose two sides both offer words alternates its grant between them. With N=5 and all inputs and the output always ready, input 4 (passed straight to the root) wins half of the output slots, and each of inputs 0 to 3 wins some slots.
- R9: With `out_ready` high and the tree idle, a word offered at input i becomes visible at the output after as many clock edges as there are nodes on its path. With N=5 that is 3 edges for inputs 0 to 3 and 1 edge for input 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N | Per-input word-offered flag |
| in_ready | output | N | Per-input word-taken flag |
| in_data | input | N*W | Per-input words, input i in slice i |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Output word taken by the consumer |
| out_data | output | W | Output word |

## Verification
The bench uses N=5 and W=8. Five is the smallest count that exercises all three level shapes: a full pair of nodes, an odd stream that bypasses one level, and a root that joins a deep subtree with a shallow leg. The upper three data bits carry the input index and the lower five carry a per-input sequence number. The bench can therefore work out arithmetically the source, the order and the share of every word that leaves. It runs these patterns in turn: a single word, fixed per-path latency, a saturated run that measures each input's share of slots, and a run driven by an LFSR on `out_ready` that checks hold, bubble and loss behaviour on every cycle.

// File: rtl/arb_tree_pkg.sv
package arb_tree_pkg;

    // Number of streams entering tree level lvl, for n leaf inputs.
    function automatic int width_at(input int n, input int lvl);
        return (n + (1 << lvl) - 1) >> lvl;
    endfunction

    // Node count on the longest leaf-to-root path.
    function automatic int tree_depth(input int n);
        return (n <= 1) ? 0 : $clog2(n);
    endfunction

endpackage

// File: rtl/arb_tree_pick.sv
// Fair two-way chooser: a lone requester wins, a tie goes against the last winner.
module arb_tree_pick (
    input  logic a_req,
    input  logic b_req,
    input  logic last_b,
    output logic any_req,
    output logic take_b
);
    always_comb begin
        any_req = a_req | b_req;
        take_b  = b_req & (~a_req | ~last_b);
    end
endmodule

// File: rtl/arb_tree_node.sv
module arb_tree_node #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         a_valid,
    output logic         a_ready,
    input  logic [W-1:0] a_data,
    input  logic         b_valid,
    output logic         b_ready,
    input  logic [W-1:0] b_data,
    output logic         y_valid,
    input  logic         y_ready,
    output logic [W-1:0] y_data
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         empty;
        logic         last_b;
    } node_t;

    node_t state_q, state_d;
    logic  any_req;
    logic  take_b;

    arb_tree_pick u_pick (
        .a_req  (a_valid),
        .b_req  (b_valid),
        .last_b (state_q.last_b),
        .any_req(any_req),
        .take_b (take_b)
    );

    always_comb begin
        state_d = state_q;
        a_ready = 1'b0;
        b_ready = 1'b0;
        if (state_q.empty) begin
            if (any_req) begin
                a_ready        = ~take_b;
                b_ready        = take_b;
                state_d.word   = take_b ? b_data : a_data;
                state_d.empty  = 1'b0;
                state_d.last_b = take_b;
            end
        end else if (y_ready) begin
            // Free the slot only on a real hand-off.
            state_d.empty = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{word: '0, empty: 1'b1, last_b: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    assign y_valid = ~state_q.empty;
    assign y_data  = state_q.word;
endmodule

// File: rtl/arb_tree.sv
module arb_tree #(
    parameter int N = 5,
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        in_valid,
    output logic [N-1:0]        in_ready,
    input  logic [N-1:0][W-1:0] in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [W-1:0]        out_data
);
    localparam int LEVELS = arb_tree_pkg::tree_depth(N);

    logic [N-1:0]        lv_valid [LEVELS+1];
    logic [N-1:0]        lv_ready [LEVELS+1];
    logic [N-1:0][W-1:0] lv_data  [LEVELS+1];

    assign lv_valid[0] = in_valid;
    assign lv_data[0]  = in_data;
    assign in_ready    = lv_ready[0];

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int CI = arb_tree_pkg::width_at(N, l);
        localparam int CO = arb_tree_pkg::width_at(N, l + 1);
        localparam int NP = CI / 2;

        for (genvar j = 0; j < NP; j++) begin : g_node
            arb_tree_node #(.W(W)) u_node (
                .clk    (clk),
                .rst    (rst),
                .a_valid(lv_valid[l][2*j]),
                .a_ready(lv_ready[l][2*j]),
                .a_data (lv_data[l][2*j]),
                .b_valid(lv_valid[l][2*j+1]),
                .b_ready(lv_ready[l][2*j+1]),
                .b_data (lv_data[l][2*j+1]),
                .y_valid(lv_valid[l+1][j]),
                .y_ready(lv_ready[l+1][j]),
                .y_data (lv_data[l+1][j])
            );
        end

        if (CI % 2 == 1) begin : g_pass
            assign lv_valid[l+1][CO-1] = lv_valid[l][CI-1];
            assign lv_data[l+1][CO-1]  = lv_data[l][CI-1];
            assign lv_ready[l][CI-1]   = lv_ready[l+1][CO-1];
        end

        for (genvar k = CO; k < N; k++) begin : g_tie_up
            assign lv_valid[l+1][k] = 1'b0;
            assign lv_data[l+1][k]  = '0;
        end

        for (genvar k = CI; k < N; k++) begin : g_tie_rdy
            assign lv_ready[l][k] = 1'b0;
        end
    end

    assign lv_ready[LEVELS][0] = out_ready;
    for (genvar k = 1; k < N; k++) begin : g_tie_root
        assign lv_ready[LEVELS][k] = 1'b0;
    end

    assign out_valid = lv_valid[LEVELS][0];
    assign out_data  = lv_data[LEVELS][0];
endmodule

// File: rtl/arb_tree_chk.sv
module arb_tree_chk #(
    parameter int N = 5,
    parameter int W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [N-1:0]        in_valid,
    input logic [N-1:0]        in_ready,
    input logic [N-1:0][W-1:0] in_data,
    input logic                out_valid,
    input logic                out_ready,
    input logic [W-1:0]        out_data
);
    AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> !out_valid); // R1

    for (genvar i = 0; i < N; i++) begin : g_in
        AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
            in_ready[i] |-> in_valid[i]); // R2
    end

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid); // R3

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_data)); // R3

    AST_BUBBLE_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !out_valid); // R4
endmodule

bind arb_tree arb_tree_chk #(.N(N), .W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/arb_tree_test.sv
module arb_tree_test;
    localparam int N = 5;
    localparam int W = 8;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [N-1:0]        in_valid = '0;
    logic [N-1:0]        in_ready;
    logic [N-1:0][W-1:0] in_data = '0;
    logic                out_valid;
    logic                out_ready = 1'b0;
    logic [W-1:0]        out_data;

    int n_chk = 0;
    int n_bad = 0;
    int pend   [N];
    int seq_in [N];
    int seq_out[N];
    int won    [N];
    int rx = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    arb_tree #(.N(N), .W(W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            in_valid[i] = (pend[i] > 0);
            in_data[i]  = {3'(i), 5'(seq_in[i])};
        end
    endtask

    task automatic clear_srcs();
        for (int i = 0; i < N; i++) begin
            pend[i] = 0; seq_in[i] = 0; seq_out[i] = 0; won[i] = 0;
        end
        rx = 0;
    endtask

    task automatic do_reset();
        clear_srcs();
        drive();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!out_valid, "R1", int'(out_valid), 0);
    endtask

    // One clock: record planned handshakes, clock, update the model, check.
    task automatic step();
        logic [N-1:0] fi;
        logic fo, hold;
        logic [W-1:0] hd;
        int idx;
        drive();
        #1;
        fi   = in_valid & in_ready;
        fo   = out_valid & out_ready;
        hold = out_valid & ~out_ready;
        hd   = out_data;
        for (int i = 0; i < N; i++)
            if (in_ready[i] && !in_valid[i]) chk(1'b0, "R2", 1, 0);
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++)
            if (fi[i]) begin pend[i]--; seq_in[i]++; end
        if (fo) begin
            idx = int'(hd[7:5]);
            chk(idx < N, "R7", idx, N - 1);
            if (idx < N) begin
                chk(int'(hd[4:0]) == (seq_out[idx] % 32), "R7", int'(hd[4:0]), seq_out[idx] % 32);
                seq_out[idx]++;
                won[idx]++;
            end
            rx++;
        end
        drive();
        #1;
        if (hold) begin
            chk(out_valid, "R3", int'(out_valid), 1);
            chk(out_data == hd, "R3", int'(out_data), int'(hd));
        end
        if (fo) chk(!out_valid, "R4", int'(out_valid), 0);
    endtask

    initial begin
        int lat;
        int sent;
        @(negedge clk);
        do_reset();

        // R5: ready with nothing buffered, then one word must still arrive.
        out_ready = 1'b1;
        for (int c = 0; c < 5; c++) begin
            step();
            chk(!out_valid, "R5", int'(out_valid), 0);
        end
        pend[2] = 1;
        for (int c = 0; c < 6; c++) step();
        chk(seq_out[2] == 1 && rx == 1, "R5", rx, 1);

        // R6: input 0 alone, output stalled one cycle, then ready.
        do_reset();
        pend[0]   = 1;
        out_ready = 1'b0;
        step();
        out_ready = 1'b1;
        step();
        drive(); #1;
        chk(!out_valid, "R6", int'(out_valid), 0);
        step();
        chk(out_valid, "R6", int'(out_valid), 1);
        chk(out_data == 8'h00, "R6", int'(out_data), 0);
        step();
        chk(rx == 1, "R6", rx, 1);

        // R9: per-path latency through an idle tree.
        for (int i = 0; i < N; i++) begin
            do_reset();
            out_ready = 1'b1;
            pend[i]   = 1;
            lat = 0;
            while (!out_valid && lat < 10) begin
                step();
                lat++;
            end
            chk(lat == ((i == N - 1) ? 1 : 3), "R9", lat, (i == N - 1) ? 1 : 3);
            chk(out_data == {3'(i), 5'd0}, "R9", int'(out_data), i * 32);
            step();
        end

        // R8: saturated inputs, always-ready output; measure slot shares.
        do_reset();
        out_ready = 1'b1;
        for (int i = 0; i < N; i++) pend[i] = 100000;
        for (int c = 0; c < 40; c++) step();
        for (int i = 0; i < N; i++) won[i] = 0;
        rx = 0;
        while (rx < 64) step();
        chk(won[4] >= 28 && won[4] <= 36, "R8", won[4], 32);
        for (int i = 0; i < N - 1; i++) chk(won[i] > 0, "R8", won[i], 8);

        // R7 with R3/R4 every cycle: bounded bursts, LFSR-driven output stalls.
        do_reset();
        for (int i = 0; i < N; i++) pend[i] = 40;
        for (int c = 0; c < 3000; c++) begin
            lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = lfsr[0] | lfsr[3];
            step();
        end
        out_ready = 1'b1;
        for (int c = 0; c < 20; c++) step();
        sent = 0;
        for (int i = 0; i < N; i++) begin
            chk(seq_out[i] == 40, "R7", seq_out[i], 40);
            sent += seq_in[i];
        end
        chk(rx == sent, "R7", rx, sent);
        chk(!out_valid, "R7", int'(out_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule